// File: doc/BRIEF.md
# Reconfigurable Block Transpose-Form FIR Filter

This block filters a stream of signed samples that arrive L at a time, one block per clock, and delivers L filter outputs per clock. The filter has N = M·L taps. The taps are cut into M short weight vectors of L coefficients each. A register unit turns the current block and the tail of the previous block into an L×L sample matrix. M inner-product units multiply that same matrix by their own short vector. A transpose-form chain of one-block delays then adds the partial results. The vector holding the oldest taps enters at the far end of the chain.

A built-in coefficient store holds P selectable filters. It is organised as one P-word ROM per tap, so a single select value fetches all N taps in one clock. The select input is captured with the data block. A new selection applies to the products of the block captured at that same edge. While the delay chain still carries partial sums made with the old taps, the outputs mix the two filters. A small state machine therefore flags the outputs as valid only once the chain is clean. It has two states. FILL means the chain still holds stale or mixed data. RUN means the outputs are pure results of the captured filter. The transitions are:
- FILL→RUN when the M-th clock edge with an unchanged selection is reached.
- FILL→FILL, with the count restarted, when the selection changes while filling.
- RUN→FILL when the selection changes.

Top module: `tbf_filter`

## Requirements
- R1: Input lane l (bits [l·B +: B]) carries sample x(kL−l), so lane 0 is the newest sample of the block. Output lane l (bits [l·W +: W]) carries y(kL−l) = Σ h(i)·x(kL−l−i) over i = 0..N−1. Both are two's complement.
- R2: The outputs for the block presented before a rising edge appear on `out_blk` after that same edge, with no further delay.
- R3: Each output uses the last L−1 samples of the previous block as well as the current block, so the history carries across block boundaries.
- R4: Tap i of filter p equals ((37·p + 13·i + 5) mod 2^B) − 2^(B−1).
- R5: The value on `flt_sel` captured at an edge selects the taps used for the products of the block captured at that same edge.
- R6: After reset, `out_valid` is low until the M-th clock edge. It is high after that edge if the selection did not change in between.
- R7: An edge at which `flt_sel` differs from the previously captured selection forces `out_valid` low. It stays low until M edges have elapsed, counting that edge as the first. A further change during this wait restarts the count.
- R8: Presenting the same selection again does not disturb `out_valid` while it is high.
- R9: Full-scale inputs and taps produce exact results. Each output lane is W = 2B + ceil(log2 N) bits wide.
- R10: While reset is asserted, the outputs read zero and `out_valid` is low. After reset, all samples before the first block count as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_blk | input | L·B | Input block, lane l = x(kL−l) |
| flt_sel | input | ceil(log2 P) | Filter selection, captured with the block |
| out_blk | output | L·W | Output block, lane l = y(kL−l) |
| out_valid | output | 1 | Outputs are results of one filter only |

## Verification
The assertions assume that reset is held for at least two clock edges, so that the one-block history checks never look back past reset. They also assume that `flt_sel` always stays below P and that every input lane lies within the signed B-bit range; the output range check depends on that bound. The stimulus asserts reset for two edges at the start and again in mid-stream. It drives only selections 0 to 3, and it packs every sample from a signed 8-bit value, including runs at −128 and +127.

// File: rtl/tbf_pkg.sv
package tbf_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;

    // Tap i of filter p, signed value in a bits-wide word.
    function automatic int coef_word(input int p, input int i, input int bits);
        int span;
        span = 1 << bits;
        return ((37 * p + 13 * i + 5) % span) - span / 2;
    endfunction

endpackage

// File: rtl/tbf_coef_store.sv
module tbf_coef_store #(
    parameter int B  = 8,
    parameter int N  = 16,
    parameter int P  = 4,
    parameter int SW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [SW-1:0]  sel,
    output logic [N*B-1:0] coef_flat
);

    // One P-word ROM per tap; all taps fetched in the same clock.
    for (genvar i = 0; i < N; i++) begin : g_tap
        logic [B-1:0] rom [P];
        logic [B-1:0] coef_r;

        for (genvar p = 0; p < P; p++) begin : g_word
            assign rom[p] = B'(tbf_pkg::coef_word(p, i, B));
        end

        always_ff @(posedge clk) begin
            if (rst) coef_r <= '0;
            else     coef_r <= rom[sel];
        end

        assign coef_flat[i*B +: B] = coef_r;
    end

endmodule

// File: rtl/tbf_row_unit.sv
module tbf_row_unit #(
    parameter int B = 8,
    parameter int L = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [L*B-1:0]   in_blk,
    output logic [L*L*B-1:0] rows
);

    logic [B-1:0] cur_q  [L];
    logic [B-1:0] hold_q [L-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < L; j++)     cur_q[j]  <= '0;
            for (int j = 0; j < L - 1; j++) hold_q[j] <= '0;
        end else begin
            for (int j = 0; j < L; j++)     cur_q[j]  <= in_blk[j*B +: B];
            for (int j = 0; j < L - 1; j++) hold_q[j] <= cur_q[j];
        end
    end

    // Row l, element j holds x(kL-l-j): from the current block when
    // l+j < L, otherwise from the tail of the previous block.
    for (genvar l = 0; l < L; l++) begin : g_row
        for (genvar j = 0; j < L; j++) begin : g_col
            if (l + j < L) begin : g_cur
                assign rows[(l*L + j)*B +: B] = cur_q[l + j];
            end else begin : g_old
                assign rows[(l*L + j)*B +: B] = hold_q[l + j - L];
            end
        end
    end

    // The bottom row must reuse the front of the block seen one clock earlier.
    for (genvar j = 0; j < L - 1; j++) begin : g_hchk
        // R3
        hold_row_chk: assert property (@(posedge clk) disable iff (rst)
            rows[((L-1)*L + j + 1)*B +: B] == $past(rows[j*B +: B]));
    end

endmodule

// File: rtl/tbf_ipu.sv
module tbf_ipu #(
    parameter int B = 8,
    parameter int L = 4,
    parameter int W = 20
) (
    input  logic [L*L*B-1:0] rows,
    input  logic [L*B-1:0]   wvec,
    output logic [L*W-1:0]   part
);

    for (genvar l = 0; l < L; l++) begin : g_cell
        logic signed [B-1:0]   smp;
        logic signed [B-1:0]   wgt;
        logic signed [2*B-1:0] prod;
        logic signed [W-1:0]   acc;

        always_comb begin
            acc  = '0;
            smp  = '0;
            wgt  = '0;
            prod = '0;
            for (int j = 0; j < L; j++) begin
                smp  = rows[(l*L + j)*B +: B];
                wgt  = wvec[j*B +: B];
                prod = smp * wgt;
                acc  = acc + W'(prod);
            end
        end

        assign part[l*W +: W] = acc;
    end

endmodule

// File: rtl/tbf_select_fsm.sv
module tbf_select_fsm #(
    parameter int M  = 4,
    parameter int SW = 2,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sel,
    output logic          valid
);
    import tbf_pkg::*;

    fill_state_e   state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [SW-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FILL;
            cnt   <= '0;
            sel_q <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            sel_q <= sel;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_FILL: begin
                if (sel != sel_q) begin
                    cnt_nxt = CW'(1);
                end else if (cnt == CW'(M - 1)) begin
                    state_nxt = ST_RUN;
                end else begin
                    cnt_nxt = cnt + CW'(1);
                end
            end
            ST_RUN: begin
                if (sel != sel_q) begin
                    state_nxt = ST_FILL;
                    cnt_nxt   = CW'(1);
                end
            end
            default: state_nxt = ST_FILL;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_RUN:  valid = 1'b1;
            default: valid = 1'b0;
        endcase
    end

    // R7
    reselect_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (sel != sel_q) |=> !valid);

    // R8
    same_sel_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && sel == sel_q) |=> valid);

    // R6
    run_sel_stable_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> $stable(sel_q));

    // R6
    fill_count_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(M - 1));

endmodule

// File: rtl/tbf_filter.sv
module tbf_filter #(
    parameter  int B  = 8,
    parameter  int L  = 4,
    parameter  int M  = 4,
    parameter  int P  = 4,
    localparam int N  = M * L,
    localparam int W  = 2 * B + $clog2(N),
    localparam int SW = (P > 1) ? $clog2(P) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [L*B-1:0] in_blk,
    input  logic [SW-1:0]  flt_sel,
    output logic [L*W-1:0] out_blk,
    output logic           out_valid
);

    localparam int CW  = $clog2(M + 1);
    localparam int LIM = N * (2 ** (2 * B - 2));

    logic [N*B-1:0]   coef_flat;
    logic [L*L*B-1:0] rows;
    logic [L*W-1:0]   part [M];

    tbf_coef_store #(.B(B), .N(N), .P(P), .SW(SW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .sel       (flt_sel),
        .coef_flat (coef_flat)
    );

    tbf_row_unit #(.B(B), .L(L)) u_rows (
        .clk    (clk),
        .rst    (rst),
        .in_blk (in_blk),
        .rows   (rows)
    );

    for (genvar m = 0; m < M; m++) begin : g_ipu
        tbf_ipu #(.B(B), .L(L), .W(W)) u_ipu (
            .rows (rows),
            .wvec (coef_flat[m*L*B +: L*B]),
            .part (part[m])
        );
    end

    // Transpose chain: stage M-1 takes the oldest taps, each stage adds
    // its own partial result to the one-block-delayed sum behind it.
    logic signed [W-1:0] dly [1:M-1][L];

    for (genvar m = 1; m < M; m++) begin : g_stage
        for (genvar l = 0; l < L; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    dly[m][l] <= '0;
                end else if (m == M - 1) begin
                    dly[m][l] <= part[m][l*W +: W];
                end else begin
                    dly[m][l] <= dly[(m == M - 1) ? m : m + 1][l] + part[m][l*W +: W];
                end
            end
        end
    end

    for (genvar l = 0; l < L; l++) begin : g_out
        logic signed [W-1:0] lane_y;
        assign lane_y = dly[1][l] + part[0][l*W +: W];
        assign out_blk[l*W +: W] = lane_y;

        // R9
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            (int'(lane_y) <= LIM) && (int'(lane_y) >= -LIM));
    end

    tbf_select_fsm #(.M(M), .SW(SW), .CW(CW)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .sel   (flt_sel),
        .valid (out_valid)
    );

endmodule

// File: tb/tb_tbf_filter.sv
module tb_tbf_filter;

    localparam int B = 8;
    localparam int L = 4;
    localparam int M = 4;
    localparam int P = 4;
    localparam int N = M * L;
    localparam int W = 2 * B + $clog2(N);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [L*B-1:0] in_blk = '0;
    logic [1:0]     flt_sel = '0;
    logic [L*W-1:0] out_blk;
    logic           out_valid;

    tbf_filter #(.B(B), .L(L), .M(M), .P(P)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_blk    (in_blk),
        .flt_sel   (flt_sel),
        .out_blk   (out_blk),
        .out_valid (out_valid)
    );

    always #5 clk = ~clk;

    int    xh [0:4095];
    int    nx;
    int    run;
    int    last_sel;
    int    n_cmp;
    int    n_bad;
    string tag_y;
    string tag_v;

    function automatic int hval(input int p, input int i);
        return ((37 * p + 13 * i + 5) % 256) - 128;
    endfunction

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // Called at a falling edge; ends at the next falling edge.
    task automatic do_reset();
        rst     = 1'b1;
        in_blk  = '0;
        flt_sel = '0;
        @(posedge clk);
        @(posedge clk);
        #2;
        chk(out_valid == 1'b0, "R10 valid in reset", int'(out_valid), 0);
        for (int l = 0; l < L; l++)
            chk(out_blk[l*W +: W] == '0, "R10 output in reset",
                int'($signed(out_blk[l*W +: W])), 0);
        @(negedge clk);
        rst      = 1'b0;
        nx       = 0;
        run      = 0;
        last_sel = 0;
    endtask

    // Samples a0..a3 in time order (a3 newest). Starts at a falling edge.
    task automatic step(input int a0, input int a1, input int a2, input int a3, input int sel);
        int exp;
        int n;
        in_blk  = {B'(a0), B'(a1), B'(a2), B'(a3)};
        flt_sel = 2'(sel);
        @(posedge clk);
        xh[nx] = a0; xh[nx+1] = a1; xh[nx+2] = a2; xh[nx+3] = a3;
        nx = nx + 4;
        if (sel != last_sel) run = 1;
        else                 run = run + 1;
        last_sel = sel;
        #2;
        chk(out_valid == (run >= M), tag_v, int'(out_valid), int'(run >= M));
        if (run >= M) begin
            for (int l = 0; l < L; l++) begin
                n   = nx - 1 - l;
                exp = 0;
                for (int i = 0; i < N; i++)
                    if (n - i >= 0) exp += hval(sel, i) * xh[n - i];
                chk(int'($signed(out_blk[l*W +: W])) == exp, tag_y,
                    int'($signed(out_blk[l*W +: W])), exp);
            end
        end
        @(negedge clk);
    endtask

    function automatic int rs();
        return int'($urandom_range(0, 255)) - 128;
    endfunction

    task automatic step_rand(input int sel);
        step(rs(), rs(), rs(), rs(), sel);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        n_cmp = 0;
        n_bad = 0;
        @(negedge clk);
        do_reset();

        // Filling after reset, then random data on filter 0.
        tag_v = "R6 valid after reset";
        tag_y = "R1 random block";
        for (int k = 0; k < 12; k++) step_rand(0);

        // Impulse on filter 1 exposes the taps.
        tag_v = "R7 valid after reselect";
        tag_y = "R4 impulse taps";
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 1);
        for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 1);
        for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 1);

        // Single isolated block; its outputs must appear at once.
        tag_y = "R2 same-edge outputs";
        step(17, -5, 33, -90, 1);
        step(0, 0, 0, 0, 1);

        // Reselect with random data; new taps apply to that same block.
        tag_y = "R5 taps of new selection";
        for (int k = 0; k < 10; k++) step_rand(2);

        // Change again during fill: count restarts.
        tag_v = "R7 restart in fill";
        tag_y = "R3 history across blocks";
        step_rand(1);
        step_rand(1);
        step_rand(3);
        for (int k = 0; k < 8; k++) step_rand(3);

        // Same selection presented repeatedly: stays valid.
        tag_v = "R8 same selection";
        for (int k = 0; k < 6; k++) step_rand(3);

        // Full-scale data on filters 3 and 0.
        tag_v = "R7 valid after reselect";
        tag_y = "R9 full scale";
        for (int k = 0; k < 8; k++) step(-128, -128, -128, -128, 3);
        for (int k = 0; k < 8; k++) step(127, -128, 127, -128, 0);
        for (int k = 0; k < 8; k++) step(-128, -128, -128, -128, 0);

        // Reset mid-stream: history must be cleared.
        do_reset();
        tag_v = "R10 valid after second reset";
        tag_y = "R10 cleared history";
        for (int k = 0; k < 10; k++) step_rand(1);

        summary();
    end

endmodule